// File: doc/BRIEF.md
# Two-Stage Watchdog Timer

This block is a system watchdog with a small register bus. A down-counter loses one count on each slow tick, and software keeps it from running out by writing to the reload register. The tick comes from an internal prescaler that divides the system clock by a parameter. In the intended system one tick lasts about 0.6 s. Simulation uses a short divide ratio instead.

A build parameter picks one of two expiry schemes:

- **Two-stage mode (6-bit count).** The first underflow only raises a timeout flag, and the counter reloads and keeps counting. A system-reset request follows only if a second underflow arrives while that flag is still set. Clearing the flag, which is the keepalive, means the count must run out twice more before a reset.
- **Single-stage mode (10-bit count).** Every underflow is final and asks for a reset at once.

In both modes a no-reboot bit can veto the reset request. A halt bit freezes the counter. The status flags clear when a one is written to them.

The bus is a plain synchronous write strobe with a 5-bit address and 16-bit data. There is no back-pressure, so a write takes effect on the clock edge where `bus_we` is high. Reads are combinational from `bus_addr`. No register carries streaming data, so the block has no valid/ready interface.

Top module: `wdog2_top`

## Requirements
- R1: After reset the control register (0x08) reads 0x0801, meaning halt (bit 11) and no-reboot (bit 0) are both set. Both status registers (0x04, 0x06) read 0. The initial value and the count equal the INIT_DEFAULT parameter, and `sys_rst_req` is low.
- R2: While running, the counter decreases by one every TICK_DIV clocks. The first decrement comes TICK_DIV clocks after a reload or after halt clears. Address 0x00 reads the live count, zero-extended.
- R3: Bit 11 of 0x08 is the halt bit. When it is 1 the count and the prescaler hold still; when it is 0 they run. Bits 11 and 0 of 0x08 read back as written.
- R4: Any write to 0x00 loads the counter with the initial value and restarts the prescaler, whatever the data.
- R5: The initial value is bits [5:0] of the byte at 0x01 in two-stage mode, or bits [9:0] of the word at 0x12 in single-stage mode. The other bits of that register are plain read/write storage.
- R6: A write whose initial-value field is 0, 1, 2 or 3 leaves the field unchanged, while the upper storage bits still take the written data.
- R7: A tick that finds the count at 0 is an underflow. On an underflow the counter reloads from the initial value and keeps counting.
- R8: In two-stage mode an underflow with the timeout flag (0x04 bit 3) clear sets that flag and requests no reset.
- R9: In two-stage mode an underflow with the timeout flag already set is a second timeout. It sets bit 1 of 0x06 and pulses `sys_rst_req` high for exactly one clock. When the pulse is issued, it also sets the boot flag (0x06 bit 2).
- R10: Writing 1 to a status bit clears it, and writing 0 leaves it unchanged. A flag being set in the same cycle wins over the clear.
- R11: While no-reboot is 1, a second timeout still sets bit 1 of 0x06, but neither `sys_rst_req` nor the boot flag is raised.
- R12: In single-stage mode every underflow sets the timeout flag, the second-timeout flag and, unless vetoed, the reset pulse and the boot flag.
- R13: Clearing the timeout flag in two-stage mode means two further underflows are needed before a second timeout.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low synchronous reset |
| bus_we | input | 1 | Write strobe, one write per cycle |
| bus_addr | input | 5 | Register byte offset |
| bus_wdata | input | 16 | Write data |
| bus_rdata | output | 16 | Read data for `bus_addr`, combinational |
| sys_rst_req | output | 1 | One-clock system reset request |

## Verification
The assertions check every cycle for the following:

- a count that moves without a tick or reload;
- a reload or wrap that misses the initial value;
- an illegal initial value;
- a reset pulse wider than one clock or raised under the veto;
- a reset pulse without its second-timeout and boot flags.

The bench scenarios are the only thing that shows the end-to-end timing against the prescaler period: the exact cycle of each decrement, that two underflows are needed after a keepalive, that single-stage mode resets on the first underflow, and that the write-one-to-clear and read-back encodings behave as stated.

// File: rtl/wdt2_pkg.sv
package wdt2_pkg;
  localparam logic [4:0] OFF_RELOAD = 5'h00;
  localparam logic [4:0] OFF_INIT_B = 5'h01;
  localparam logic [4:0] OFF_STS_A  = 5'h04;
  localparam logic [4:0] OFF_STS_B  = 5'h06;
  localparam logic [4:0] OFF_CTRL   = 5'h08;
  localparam logic [4:0] OFF_INIT_W = 5'h12;

  localparam int BIT_HALT  = 11;
  localparam int BIT_NOREB = 0;
  localparam int BIT_TMO   = 3;
  localparam int BIT_SEC   = 1;
  localparam int BIT_BOOT  = 2;

  function automatic int cnt_width(input bit two_stage);
    return two_stage ? 6 : 10;
  endfunction

  function automatic int init_reg_width(input bit two_stage);
    return two_stage ? 8 : 16;
  endfunction
endpackage

// File: rtl/wdt2_prescaler.sv
module wdt2_prescaler #(
  parameter int DIV = 1000
) (
  input  logic clk,
  input  logic rst_n,
  input  logic run,
  input  logic restart,
  output logic tick
);
  localparam int PW = (DIV > 1) ? $clog2(DIV) : 1;
  localparam logic [PW-1:0] LAST = PW'(DIV - 1);

  logic [PW-1:0] pre_q;

  assign tick = run && !restart && (pre_q == LAST);

  always_ff @(posedge clk) begin
    if (!rst_n)                     pre_q <= '0;
    else if (restart || !run)       pre_q <= '0;
    else if (pre_q == LAST)         pre_q <= '0;
    else                            pre_q <= pre_q + PW'(1);
  end

  // R2: ticks are spaced at least two clocks apart when DIV >= 2
  p_tick_gap_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (DIV > 1) && tick |=> !tick);
endmodule

// File: rtl/wdt2_counter.sv
module wdt2_counter #(
  parameter int CW      = 6,
  parameter int RST_VAL = 50
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          tick,
  input  logic          reload,
  input  logic [CW-1:0] init_val,
  output logic [CW-1:0] count,
  output logic          expire
);
  assign expire = tick && !reload && (count == '0);

  always_ff @(posedge clk) begin
    if (!rst_n)          count <= CW'(RST_VAL);
    else if (reload)     count <= init_val;
    else if (tick) begin
      if (count == '0)   count <= init_val;
      else               count <= count - CW'(1);
    end
  end

  p_hold_r3: assert property (@(posedge clk) disable iff (!rst_n)
    !tick && !reload |=> $stable(count));
  p_reload_r4: assert property (@(posedge clk) disable iff (!rst_n)
    reload |=> count == $past(init_val));
  p_dec_r2: assert property (@(posedge clk) disable iff (!rst_n)
    tick && !reload && count != '0 |=> count == $past(count) - CW'(1));
  p_wrap_r7: assert property (@(posedge clk) disable iff (!rst_n)
    expire |=> count == $past(init_val));
endmodule

// File: rtl/wdt2_regs.sv
module wdt2_regs #(
  parameter bit TWO_STAGE    = 1'b1,
  parameter int INIT_DEFAULT = 50
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        bus_we,
  input  logic [4:0]  bus_addr,
  input  logic [15:0] bus_wdata,
  output logic [15:0] bus_rdata,
  input  logic [wdt2_pkg::cnt_width(TWO_STAGE)-1:0] count,
  input  logic        expire,
  output logic [wdt2_pkg::cnt_width(TWO_STAGE)-1:0] init_val,
  output logic        halt,
  output logic        reload,
  output logic        sys_rst_req
);
  import wdt2_pkg::*;
  localparam int CW = cnt_width(TWO_STAGE);
  localparam int IW = init_reg_width(TWO_STAGE);
  localparam logic [4:0] OFF_INIT = TWO_STAGE ? OFF_INIT_B : OFF_INIT_W;

  logic [IW-1:0] init_q;
  logic halt_q, noreb_q, tmo_q, sec_q, boot_q, rst_q;
  logic wr_init, wr_ctrl, wr_sa, wr_sb, second, fire;
  logic [IW-1:0] wval;
  logic unused_wdata;

  assign unused_wdata = ^bus_wdata;
  assign wr_init = bus_we && bus_addr == OFF_INIT;
  assign wr_ctrl = bus_we && bus_addr == OFF_CTRL;
  assign wr_sa   = bus_we && bus_addr == OFF_STS_A;
  assign wr_sb   = bus_we && bus_addr == OFF_STS_B;
  assign reload  = bus_we && bus_addr == OFF_RELOAD;
  assign wval    = bus_wdata[IW-1:0];

  assign second = TWO_STAGE ? (expire && tmo_q) : expire;
  assign fire   = second && !noreb_q;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      init_q  <= IW'(INIT_DEFAULT);
      halt_q  <= 1'b1;
      noreb_q <= 1'b1;
      tmo_q   <= 1'b0;
      sec_q   <= 1'b0;
      boot_q  <= 1'b0;
      rst_q   <= 1'b0;
    end else begin
      if (wr_init) begin
        if (wval[CW-1:0] >= CW'(4)) init_q <= wval;
        else                        init_q <= {wval[IW-1:CW], init_q[CW-1:0]};
      end
      if (wr_ctrl) begin
        halt_q  <= bus_wdata[BIT_HALT];
        noreb_q <= bus_wdata[BIT_NOREB];
      end
      if (wr_sa && bus_wdata[BIT_TMO])  tmo_q  <= 1'b0;
      if (wr_sb && bus_wdata[BIT_SEC])  sec_q  <= 1'b0;
      if (wr_sb && bus_wdata[BIT_BOOT]) boot_q <= 1'b0;
      if (expire) tmo_q  <= 1'b1;
      if (second) sec_q  <= 1'b1;
      if (fire)   boot_q <= 1'b1;
      rst_q <= fire;
    end
  end

  assign init_val    = init_q[CW-1:0];
  assign halt        = halt_q;
  assign sys_rst_req = rst_q;

  always_comb begin
    bus_rdata = '0;
    case (bus_addr)
      OFF_RELOAD: bus_rdata = 16'(count);
      OFF_INIT:   bus_rdata = 16'(init_q);
      OFF_STS_A:  bus_rdata[BIT_TMO] = tmo_q;
      OFF_STS_B: begin
        bus_rdata[BIT_SEC]  = sec_q;
        bus_rdata[BIT_BOOT] = boot_q;
      end
      OFF_CTRL: begin
        bus_rdata[BIT_HALT]  = halt_q;
        bus_rdata[BIT_NOREB] = noreb_q;
      end
      default: bus_rdata = '0;
    endcase
  end

  p_init_legal_r6: assert property (@(posedge clk) disable iff (!rst_n)
    init_val >= CW'(4));
  p_rst_pulse_r9: assert property (@(posedge clk) disable iff (!rst_n)
    sys_rst_req |=> !sys_rst_req);
  p_rst_flags_r9: assert property (@(posedge clk) disable iff (!rst_n)
    sys_rst_req |-> sec_q && boot_q);
  p_veto_r11: assert property (@(posedge clk) disable iff (!rst_n)
    sys_rst_req |-> !$past(noreb_q));

  generate
    if (TWO_STAGE) begin : g_two
      p_first_quiet_r8: assert property (@(posedge clk) disable iff (!rst_n)
        expire && !tmo_q |=> !sys_rst_req && tmo_q);
    end else begin : g_one
      p_every_r12: assert property (@(posedge clk) disable iff (!rst_n)
        expire |=> tmo_q && sec_q);
    end
  endgenerate
endmodule

// File: rtl/wdog2_top.sv
module wdog2_top #(
  parameter bit TWO_STAGE    = 1'b1,
  parameter int TICK_DIV     = 1000,
  parameter int INIT_DEFAULT = 50
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        bus_we,
  input  logic [4:0]  bus_addr,
  input  logic [15:0] bus_wdata,
  output logic [15:0] bus_rdata,
  output logic        sys_rst_req
);
  localparam int CW = wdt2_pkg::cnt_width(TWO_STAGE);

  logic          tick, reload, expire, halt;
  logic [CW-1:0] count, init_val;

  wdt2_prescaler #(.DIV(TICK_DIV)) u_pre (
    .clk(clk), .rst_n(rst_n), .run(!halt), .restart(reload), .tick(tick));

  wdt2_counter #(.CW(CW), .RST_VAL(INIT_DEFAULT)) u_cnt (
    .clk(clk), .rst_n(rst_n), .tick(tick), .reload(reload),
    .init_val(init_val), .count(count), .expire(expire));

  wdt2_regs #(.TWO_STAGE(TWO_STAGE), .INIT_DEFAULT(INIT_DEFAULT)) u_regs (
    .clk(clk), .rst_n(rst_n), .bus_we(bus_we), .bus_addr(bus_addr),
    .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .count(count),
    .expire(expire), .init_val(init_val), .halt(halt), .reload(reload),
    .sys_rst_req(sys_rst_req));
endmodule

// File: tb/wdog2_tb.sv
`timescale 1ns/1ps
module wdog2_top_tb_top;
  localparam int P = 4;
  localparam int INIT0 = 10;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic bus_we = 1'b0;
  logic [4:0] bus_addr = '0;
  logic [15:0] bus_wdata = '0;
  logic [15:0] rd_two, rd_one;
  logic rst_two, rst_one;
  int checks = 0, failures = 0;
  int n_two = 0, n_one = 0;
  bit done = 1'b0;

  always #2 clk = ~clk;

  wdog2_top #(.TWO_STAGE(1'b1), .TICK_DIV(P), .INIT_DEFAULT(INIT0)) dut_i (
    .clk(clk), .rst_n(rst_n), .bus_we(bus_we), .bus_addr(bus_addr),
    .bus_wdata(bus_wdata), .bus_rdata(rd_two), .sys_rst_req(rst_two));
  wdog2_top #(.TWO_STAGE(1'b0), .TICK_DIV(P), .INIT_DEFAULT(INIT0)) dut_s_i (
    .clk(clk), .rst_n(rst_n), .bus_we(bus_we), .bus_addr(bus_addr),
    .bus_wdata(bus_wdata), .bus_rdata(rd_one), .sys_rst_req(rst_one));

  // one increment per high cycle, so a wide pulse shows up as a larger count
  always @(posedge clk) begin
    if (rst_two) n_two <= n_two + 1;
    if (rst_one) n_one <= n_one + 1;
  end

  task automatic chk(input string tag, input int got, input int exp);
    checks++;
    if (got != exp) begin
      failures++;
      $display("FAIL %s got=0x%0h exp=0x%0h", tag, got, exp);
    end
  endtask

  task automatic wr(input logic [4:0] a, input logic [15:0] d);
    @(negedge clk);
    bus_we = 1'b1; bus_addr = a; bus_wdata = d;
    @(negedge clk);
    bus_we = 1'b0;
  endtask

  task automatic rd(input logic [4:0] a, output int v2, output int v1);
    bus_addr = a;
    #0.5;
    v2 = rd_two; v1 = rd_one;
  endtask

  // Runs from a reload edge; checks the count every cycle and the flags at two checkpoints
  task automatic sweep(input int n, input bit nr);
    int b2, b1, v2, v1, ticks, u, e2, e1;
    b2 = n_two; b1 = n_one;
    for (int m = 1; m <= 2*(n+1)*P + 2; m++) begin
      @(negedge clk);
      ticks = m / P;
      rd(5'h00, v2, v1);
      chk("R2/R7 count two-stage", v2, n - ticks % (n+1));
      chk("R2/R7 count single-stage", v1, n - ticks % (n+1));
      if (m == (n+1)*P + 2 || m == 2*(n+1)*P + 2) begin
        u = (m - 2) / P / (n+1);
        rd(5'h04, v2, v1);
        chk("R8/R13 timeout flag two-stage", v2, 8);
        chk("R12 timeout flag single-stage", v1, 8);
        rd(5'h06, v2, v1);
        e2 = (u >= 2 ? 2 : 0) + ((u >= 2 && !nr) ? 4 : 0);
        e1 = 2 + (nr ? 0 : 4);
        chk("R9/R11/R13 second/boot two-stage", v2, e2);
        chk("R11/R12 second/boot single-stage", v1, e1);
        chk("R9/R11/R13 reset pulses two-stage", n_two - b2, (u >= 2 && !nr) ? 1 : 0);
        chk("R11/R12 reset pulses single-stage", n_one - b1, nr ? 0 : u);
      end
    end
  endtask

  initial begin
    int v2, v1, c2, c1;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    rd(5'h08, v2, v1);
    chk("R1 ctrl two", v2, 16'h0801); chk("R1 ctrl single", v1, 16'h0801);
    rd(5'h04, v2, v1); chk("R1 sts_a", v2 | v1, 0);
    rd(5'h06, v2, v1); chk("R1 sts_b", v2 | v1, 0);
    rd(5'h00, v2, v1); chk("R1 count two", v2, INIT0); chk("R1 count single", v1, INIT0);
    rd(5'h01, v2, v1); chk("R1 init two", v2, INIT0);
    rd(5'h12, v2, v1); chk("R1 init single", v1, INIT0);
    chk("R1 reset low", int'(rst_two) + int'(rst_one), 0);

    repeat (20) @(negedge clk);
    rd(5'h00, v2, v1); chk("R3 halted at reset", v2 + v1, 2*INIT0);

    wr(5'h01, 16'h00C7); rd(5'h01, v2, v1); chk("R5 init byte two", v2, 16'hC7);
    wr(5'h01, 16'h0002); rd(5'h01, v2, v1); chk("R6 illegal field kept two", v2, 16'h07);
    wr(5'h12, 16'hFC07); rd(5'h12, v2, v1); chk("R5 init word single", v1, 16'hFC07);
    wr(5'h12, 16'h0003); rd(5'h12, v2, v1); chk("R6 illegal field kept single", v1, 16'h0007);

    wr(5'h08, 16'h0000);
    rd(5'h08, v2, v1); chk("R3 ctrl readback", v2 | v1, 0);
    wr(5'h00, 16'h1234);
    rd(5'h00, v2, v1); chk("R4 reload two", v2, 7); chk("R4 reload single", v1, 7);
    sweep(7, 1'b0);

    wr(5'h06, 16'h0000); rd(5'h06, v2, v1); chk("R10 zero keeps sts_b", v2, 6);
    wr(5'h04, 16'h0000); rd(5'h04, v2, v1); chk("R10 zero keeps sts_a", v2, 8);
    wr(5'h06, 16'h0006); rd(5'h06, v2, v1); chk("R10 clear sts_b", v2 | v1, 0);
    wr(5'h08, 16'h0001); rd(5'h08, v2, v1); chk("R11 ctrl noreboot", v2, 1);
    wr(5'h04, 16'h0008); rd(5'h04, v2, v1); chk("R13 keepalive clears", v2 | v1, 0);
    wr(5'h00, 16'hBEEF);
    sweep(7, 1'b1);

    wr(5'h08, 16'h0801);
    rd(5'h08, v2, v1); chk("R3 halt readback", v2, 16'h0801);
    rd(5'h00, c2, c1);
    repeat (5*P) @(negedge clk);
    rd(5'h00, v2, v1);
    chk("R3 frozen two", v2, c2); chk("R3 frozen single", v1, c1);

    done = 1'b1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    #(200000 * 4);
    if (!done) begin
      failures++;
      $display("FAIL watchdog expired");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end
endmodule